// File: doc/BRIEF.md
# Oversampled Manchester Receiver with Preamble Clock Acquisition

This block takes a serial line sampled once per clock at `SPB` samples per bit and recovers the Manchester-coded bit stream on it. A Manchester 0 is sent as high for the first half of the cell and low for the second half. A Manchester 1 is sent as low, then high. The idle line rests high. A digital pulse filter first removes short spikes. A carrier detector then raises `carrier` on the first filtered transition after silence, and drops it when the line has been quiet for too long.

While the line is idle, an internal bit-phase counter free-runs in step with the local clock. Once carrier is up, the receiver waits for the first falling mid-cell transition, which is the centre of a Manchester 0, and freezes the counter there. It then expects a rising mid-cell edge and another falling one, each about one bit period apart. Together these make the 1010 preamble. At that second 0 (bit 4), the counter restarts at mid-cell and stays aligned to every later mid-cell edge.

From then on, every cell is sampled at three quarters of its length. The decoded bit is presented on `rx_data` with a one-cycle `clk_stb` a quarter cell into the following cell. The first strobe therefore falls in bit cell 5.

Top module: `manch_rx`

## Requirements
- R1: A level on `line_in` lasting fewer than `GLITCH` consecutive samples has no effect. On an idle line, such a pulse leaves `carrier` low. Inside a frame, it leaves the decoded bits unchanged. A pulse of exactly `GLITCH` samples is accepted.
- R2: If a transition is first driven on `line_in` in the sample taken at rising edge P, `carrier` reads 1 after edge P+`GLITCH` when it was low before.
- R3: Lock needs a falling mid-cell edge, then a rising one, then a falling one. Each gap between them must be between 3/4 and 5/4 of `SPB` samples. If the locking falling edge is first sampled at edge P, the first `clk_stb` appears after edge P+`GLITCH`+`SPB`/2+`SPB`/4.
- R4: While locked, successive `clk_stb` pulses are exactly `SPB` cycles apart, and each lasts one cycle.
- R5: The first strobe carries the bit of the locking cell, which is 0. Each later strobe carries the next cell's bit, in line order. The bit is 1 when the line is high at three quarters of the cell.
- R6: Until lock, and whenever `carrier` is low, `rx_data` reads 1 and `clk_stb` stays 0.
- R7: `carrier` falls `3*SPB/2+1` cycles after the last filtered transition. If that transition is first sampled at edge P, `carrier` reads 0 after edge P+`GLITCH`+`3*SPB/2`+1, and the receiver returns to idle.
- R8: A mid-cell edge that arrives too early during acquisition, or one missing past the window, aborts the attempt. The receiver then waits for a fresh falling edge. For a preamble of 1,0,0,1,0, lock happens at the fifth cell.
- R9: During and right after reset, `carrier` is 0, `clk_stb` is 0 and `rx_data` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one line sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Oversampled Manchester serial line, idle high |
| carrier | output | 1 | Valid line activity seen |
| clk_stb | output | 1 | One-cycle recovered bit strobe |
| rx_data | output | 1 | Decoded NRZ bit, valid with `clk_stb`, high when not locked |

## Verification
The bench builds the receiver with `SPB` = 16 and `GLITCH` = 3. The acquisition window is then 12 to 20 samples and the carrier timeout is 24. A 2-sample spike fits inside a half cell, so it can be placed in the middle of a half without touching a real edge. This lets a rejected spike (R1) be checked on the idle line and inside random frames. A spike one sample longer then proves the boundary. Quarter and three-quarter points fall on whole samples, so the first strobe, the carrier rise and the carrier fall can be checked to the exact cycle. This holds for the clean 1010 preamble, for the aborted 1,0,0,1,0 preamble, and for random payloads.

// File: rtl/manch_rx_pkg.sv
`timescale 1ns/1ps
// Shared types for the Manchester receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package manch_rx_pkg;

    // Acquisition state of the bit-phase tracker.
    typedef enum logic [2:0] {
        ACQ_IDLE,   // no carrier, phase counter free-runs on the local clock
        ACQ_HUNT,   // carrier up, waiting for the first falling mid-cell edge
        ACQ_HALT1,  // phase halted, expecting a rising mid-cell edge
        ACQ_HALT2,  // phase halted, expecting the second falling mid-cell edge
        ACQ_LOCK    // phase aligned, decoding cells
    } acq_state_t;

endpackage

// File: rtl/manch_rx_filter.sv
`timescale 1ns/1ps
// Pulse filter: the output follows the line only after the line has held a
// new level for GLITCH consecutive samples. Shorter excursions are dropped.
// Assumes: line_in is already synchronous to clk; idle level is high.
module manch_rx_filter #(
    parameter int GLITCH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic clean
);
    localparam int CW = $clog2(GLITCH + 1);

    logic [CW-1:0] run;

    // Count consecutive differing samples and adopt the new level at GLITCH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b1;
            run   <= '0;
        end else if (line_in == clean) begin
            run <= '0;
        end else if (run == CW'(GLITCH - 1)) begin
            clean <= line_in;
            run   <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    AST_FLT_CONFIRMED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean) |-> ($past(line_in) == clean)); // R1

endmodule

// File: rtl/manch_rx_carrier.sv
`timescale 1ns/1ps
// Carrier detector: flags each filtered transition, raises carrier on the
// first one after silence, drops it after SIL_LIM+1 quiet cycles.
// Assumes: clean comes from the pulse filter and resets high.
module manch_rx_carrier #(
    parameter int SPB = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clean,
    output logic edge_det,
    output logic carrier
);
    localparam int SIL_LIM = (3 * SPB) / 2;
    localparam int SW      = $clog2(SIL_LIM + 1);

    logic          clean_q;
    logic [SW-1:0] sil;

    // Delay the filtered line by one sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clean_q <= 1'b1;
        else        clean_q <= clean;
    end

    assign edge_det = clean ^ clean_q;

    // Track silence and raise or drop carrier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carrier <= 1'b0;
            sil     <= '0;
        end else if (edge_det) begin
            carrier <= 1'b1;
            sil     <= '0;
        end else if (carrier) begin
            if (sil == SW'(SIL_LIM)) carrier <= 1'b0;
            else                     sil <= sil + 1'b1;
        end
    end

    AST_CAR_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier) |-> $past(edge_det)); // R2
    AST_CAR_FALL_ON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carrier) |-> !$past(edge_det)); // R7

endmodule

// File: rtl/manch_rx_acq.sv
`timescale 1ns/1ps
// Bit-phase acquisition and decoder. A phase counter free-runs while idle,
// halts on the first falling mid-cell edge, checks the 1010 preamble spacing,
// restarts at the second 0 and then resyncs on mid-cell edges. Cells are
// sampled at 3/4 and presented with a strobe at 1/4 of the next cell.
// Assumes: SPB is a multiple of 4 and at least 8.
module manch_rx_acq
    import manch_rx_pkg::*;
#(
    parameter int SPB = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clean,
    input  logic edge_det,
    input  logic carrier,
    output logic clk_stb,
    output logic rx_data
);
    localparam int HALF = SPB / 2;
    localparam int QTR  = SPB / 4;
    localparam int TQ   = 3 * SPB / 4;
    localparam int WLO  = 3 * SPB / 4;
    localparam int WHI  = 5 * SPB / 4;
    localparam int PW   = $clog2(SPB);
    localparam int AW   = $clog2(WHI + 2);
    localparam int GW   = $clog2(SPB + 2);

    acq_state_t    state;
    logic [PW-1:0] ph;
    logic [PW-1:0] ph_inc;
    logic [AW-1:0] acq_cnt;
    logic          hold_bit;
    logic          have;
    logic          mid_win;

    // Next free-running phase value with wrap at SPB.
    always_comb begin
        ph_inc  = (ph == PW'(SPB - 1)) ? '0 : ph + 1'b1;
        mid_win = (ph >= PW'(QTR)) && (ph < PW'(TQ));
    end

    // Acquisition state machine, phase tracking and cell decoding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ACQ_IDLE;
            ph       <= '0;
            acq_cnt  <= '0;
            hold_bit <= 1'b1;
            have     <= 1'b0;
            clk_stb  <= 1'b0;
            rx_data  <= 1'b1;
        end else begin
            clk_stb <= 1'b0;
            if (!carrier) begin
                state   <= ACQ_IDLE;
                ph      <= ph_inc;
                have    <= 1'b0;
                acq_cnt <= '0;
                rx_data <= 1'b1;
            end else begin
                case (state)
                    ACQ_IDLE: begin
                        state <= ACQ_HUNT;
                        ph    <= ph_inc;
                    end
                    ACQ_HUNT: begin
                        ph <= ph_inc;
                        if (edge_det && !clean) begin
                            state   <= ACQ_HALT1;
                            acq_cnt <= AW'(1);
                        end
                    end
                    ACQ_HALT1: begin
                        if (edge_det) begin
                            if (clean && acq_cnt >= AW'(WLO)) begin
                                state   <= ACQ_HALT2;
                                acq_cnt <= AW'(1);
                            end else begin
                                state <= ACQ_HUNT;
                            end
                        end else if (acq_cnt >= AW'(WHI)) begin
                            state <= ACQ_HUNT;
                        end else begin
                            acq_cnt <= acq_cnt + 1'b1;
                        end
                    end
                    ACQ_HALT2: begin
                        if (edge_det) begin
                            if (!clean && acq_cnt >= AW'(WLO)) begin
                                state <= ACQ_LOCK;
                                ph    <= PW'(HALF + 1);
                                have  <= 1'b0;
                            end else begin
                                state <= ACQ_HUNT;
                            end
                        end else if (acq_cnt >= AW'(WHI)) begin
                            state <= ACQ_HUNT;
                        end else begin
                            acq_cnt <= acq_cnt + 1'b1;
                        end
                    end
                    ACQ_LOCK: begin
                        ph <= (edge_det && mid_win) ? PW'(HALF + 1) : ph_inc;
                        if (ph == PW'(TQ)) begin
                            hold_bit <= clean;
                            have     <= 1'b1;
                        end
                        if (ph == PW'(QTR) && have) begin
                            clk_stb <= 1'b1;
                            rx_data <= hold_bit;
                        end
                    end
                    default: state <= ACQ_IDLE;
                endcase
            end
        end
    end

    // Checker-side strobe spacing counter.
    logic [GW-1:0] gap;
    logic          gap_ok;

    // Measure cycles between strobes while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap    <= '0;
            gap_ok <= 1'b0;
        end else begin
            if (clk_stb) gap <= GW'(1);
            else if (gap != {GW{1'b1}}) gap <= gap + 1'b1;
            if (state != ACQ_LOCK) gap_ok <= 1'b0;
            else if (clk_stb)      gap_ok <= 1'b1;
        end
    end

    AST_STB_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_stb && gap_ok && state == ACQ_LOCK) |-> (gap == GW'(SPB))); // R4
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stb |=> !clk_stb); // R4
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier |=> (rx_data && !clk_stb)); // R6
    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ACQ_LOCK && $past(state) != ACQ_LOCK) |-> ($past(state) == ACQ_HALT2)); // R3
    AST_NO_EARLY_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ACQ_LOCK && $past(state) != ACQ_LOCK) |-> !clk_stb); // R6

endmodule

// File: rtl/manch_rx.sv
`timescale 1ns/1ps
// Manchester receiver top: pulse filter, carrier detector and bit-phase
// acquisition with decoder, chained in that order.
// Assumes: one line sample per clk, SPB multiple of 4, GLITCH < SPB/2.
module manch_rx #(
    parameter int SPB    = 16,
    parameter int GLITCH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic carrier,
    output logic clk_stb,
    output logic rx_data
);
    logic clean;
    logic edge_det;

    manch_rx_filter #(.GLITCH(GLITCH)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .clean   (clean)
    );

    manch_rx_carrier #(.SPB(SPB)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .clean    (clean),
        .edge_det (edge_det),
        .carrier  (carrier)
    );

    manch_rx_acq #(.SPB(SPB)) u_acq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clean    (clean),
        .edge_det (edge_det),
        .carrier  (carrier),
        .clk_stb  (clk_stb),
        .rx_data  (rx_data)
    );

endmodule

// File: tb/manch_rx_bench.sv
`timescale 1ns/1ps
// Bench for manch_rx: directed preambles, spikes and seeded random frames.
module manch_rx_bench;
    localparam int SPB    = 16;
    localparam int GLITCH = 3;
    localparam int HALF   = SPB / 2;
    localparam int QTR    = SPB / 4;
    localparam int SIL    = 3 * SPB / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b1;
    logic carrier, clk_stb, rx_data;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int last_edge = 0;

    // Monitor records
    logic car_prev = 1'b0;
    int   rise_cyc, fall_cyc, first_stb, got_n;
    logic got [0:127];

    manch_rx #(.SPB(SPB), .GLITCH(GLITCH)) u_manch_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .carrier (carrier),
        .clk_stb (clk_stb),
        .rx_data (rx_data)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Sample outputs on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (carrier && !car_prev) rise_cyc = cyc;
            if (!carrier && car_prev) fall_cyc = cyc;
            if (clk_stb) begin
                if (got_n == 0) first_stb = cyc;
                if (got_n < 128) got[got_n] = rx_data;
                got_n++;
            end
        end
        car_prev = carrier;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        got_n = 0; rise_cyc = -1; fall_cyc = -1; first_stb = -1;
    endtask

    task automatic drv(input logic v, input bit real_t);
        @(negedge clk);
        if (real_t && v !== line_in) last_edge = cyc;
        line_in = v;
    endtask

    // Send one Manchester cell; report cycles of its first and centre samples.
    task automatic send_bit(input logic b, input bit spike, output int start_c, output int centre_c);
        for (int i = 0; i < HALF; i++) begin
            if (spike && i >= 3 && i < 3 + GLITCH - 1) drv(b, 1'b0);
            else drv(~b, 1'b1);
            if (i == 0) start_c = cyc;
        end
        for (int i = 0; i < HALF; i++) begin
            drv(b, 1'b1);
            if (i == 0) centre_c = cyc;
        end
    endtask

    // One frame: preamble kind 0 = 1010, kind 1 = 10010; payload MSB first.
    task automatic run_frame(input int kind, input int n, input logic [31:0] pay, input bit spiky);
        logic [4:0] pre;
        int np, lock_i, s, c, start_d, lock_d, bad;
        pre    = (kind == 0) ? 5'b01010 : 5'b10010;
        np     = (kind == 0) ? 4 : 5;
        lock_i = np - 1;
        start_d = 0; lock_d = 0;
        clear_mon();
        for (int i = 0; i < np; i++) begin
            if (i == lock_i) chk(rx_data === 1'b1 && got_n == 0, "R6 no output before lock", got_n, 0);
            send_bit(pre[np-1-i], 1'b0, s, c);
            if (i == 0) start_d = s;
            if (i == lock_i) lock_d = c;
        end
        for (int k = 0; k < n; k++) begin
            send_bit(pay[n-1-k], spiky && ($urandom % 3 == 0), s, c);
        end
        repeat (4 * SPB) drv(line_in, 1'b1);
        chk(rise_cyc == start_d + 1 + GLITCH, "R2 carrier rise cycle", rise_cyc, start_d + 1 + GLITCH);
        chk(first_stb == lock_d + 1 + GLITCH + HALF + QTR, kind == 0 ? "R3 first strobe cycle" : "R8 relock strobe cycle",
            first_stb, lock_d + 1 + GLITCH + HALF + QTR);
        chk(got_n == n + 1, "R4 strobe count", got_n, n + 1);
        bad = 0;
        if (got_n > 0 && got[0] !== 1'b0) bad++;
        for (int k = 0; k < n && k + 1 < got_n; k++)
            if (got[k+1] !== pay[n-1-k]) bad++;
        chk(bad == 0, spiky ? "R5 R1 decoded bits with spikes" : "R5 decoded bits", bad, 0);
        chk(fall_cyc == last_edge + GLITCH + SIL + 2, "R7 carrier fall cycle", fall_cyc, last_edge + GLITCH + SIL + 2);
        chk(carrier === 1'b0 && rx_data === 1'b1, "R7 idle after drop", {carrier, rx_data}, 1);
        drv(1'b1, 1'b1);
        repeat (4 * SPB) drv(1'b1, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        got_n = 0; rise_cyc = -1; fall_cyc = -1; first_stb = -1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(carrier === 1'b0 && clk_stb === 1'b0 && rx_data === 1'b1, "R9 reset state", {carrier, clk_stb, rx_data}, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(carrier === 1'b0 && clk_stb === 1'b0 && rx_data === 1'b1, "R9 after reset", {carrier, clk_stb, rx_data}, 1);

        // R1: short spike on idle line is dropped
        clear_mon();
        repeat (GLITCH - 1) drv(1'b0, 1'b1);
        repeat (3 * SPB) drv(1'b1, 1'b1);
        chk(rise_cyc == -1 && carrier === 1'b0, "R1 short spike ignored", rise_cyc, -1);

        // R1 boundary: spike of exactly GLITCH samples is accepted
        clear_mon();
        repeat (GLITCH) drv(1'b0, 1'b1);
        repeat (4 * SPB) drv(1'b1, 1'b1);
        chk(rise_cyc != -1 && got_n == 0, "R1 full-width pulse accepted", rise_cyc, 1);

        // Directed frames: clean preamble, then aborted preamble (R8)
        run_frame(0, 8, 32'h0000_00B2, 1'b0);
        run_frame(1, 8, 32'h0000_004D, 1'b0);

        // Seeded random frames, some with spikes inside half cells
        for (int f = 0; f < 6; f++) begin
            int n;
            logic [31:0] p;
            n = 4 + int'($urandom % 25);
            p = $urandom;
            run_frame(f % 2, n, p, f >= 2);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule